// File: doc/BRIEF.md
# Numerically Controlled Waveform Generator

This block is a direct digital synthesis core. A 28-bit phase accumulator advances once per master clock by one of two stored frequency words. One of two stored 12-bit phase offsets is added to the accumulator's top bits. The resulting phase drives a 10-bit output path. That path produces one of three waveforms: an offset-binary sine built from a quarter-wave table, a linear triangle, or a full-scale square taken from the phase MSB, which can optionally be halved in frequency. A separate 1-bit square pin carries the same MSB or its divided form.

The frequency and phase words are loaded through plain write ports. The control bits are static inputs. A datapath clear parks the output at midscale without touching the stored words. A clock-sleep input freezes the output while writes are still taken. An output power-down input forces the sample to zero and leaves the square pin alone. The datapath is seven registers deep, so a new waveform starts a fixed number of clocks after the clear is released.

Top module: `dds_wavegen`

## Requirements
- R1: On each rising edge where `dp_clear` and `clk_sleep` are both 0, the accumulator adds the frequency word picked by `freq_sel`, modulo 2^28. The phase used downstream is the accumulator value plus the phase word picked by `phase_sel`, shifted left by 16.
- R2: There are two frequency words and two phase words, written with `freq_we`/`freq_wsel` and `phase_we`/`phase_wsel`. A word written at an edge is first used by the accumulator or adder at the following edge.
- R3: `rst_n` low at an edge, or `dp_clear` high at an edge, makes `sample` 512 and `square` 0 after that edge, unless `dac_off` is 1. `dp_clear` keeps all stored words.
- R4: Let N be the first edge where `dp_clear` is 0 after being 1. After edges N to N+5 `sample` is still 512. After edge N+6 it shows the waveform for phase (frequency word + offset).
- R5: In sine mode the sample is offset binary and lies within 1 LSB of 511.5 + 511.5·sin(2π(p+0.5)/1024), where p is bits 27:18 of the phase.
- R6: The sine has exact symmetry: s(p) + s(p+512) = 1023 and s(p) = s(511−p).
- R7: Triangle mode (`tri_en`=1, `msb_out_en`=0) takes t = phase bits 27:17. The sample is t[9:0] when t[10] is 0, and the bitwise inverse of t[9:0] when t[10] is 1.
- R8: Square mode (`msb_out_en`=1, `tri_en`=0) makes the sample 1023 when the square bit is 1 and 0 when it is 0. With `msb_div_bypass`=1 the square bit equals phase bit 27.
- R9: With `msb_div_bypass`=0 the square bit is a toggle. It starts at 0 after a clear and flips on each 0-to-1 change of phase bit 27 across consecutive valid samples. The `square` pin follows this selection in every mode.
- R10: The combination `msb_out_en`=1 with `tri_en`=1 produces the sine.
- R11: While `clk_sleep` is 1, `sample` and `square` hold their values. Writes are still accepted and are used once sleep is released.
- R12: `dac_off`=1 forces `sample` to 0 in the same cycle, without waiting for a clock edge, and leaves `square` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; clears everything |
| freq_we | input | 1 | Frequency word write strobe |
| freq_wsel | input | 1 | Which frequency word to write |
| freq_wdata | input | 28 | Frequency word data |
| phase_we | input | 1 | Phase word write strobe |
| phase_wsel | input | 1 | Which phase word to write |
| phase_wdata | input | 12 | Phase word data |
| freq_sel | input | 1 | Active frequency word |
| phase_sel | input | 1 | Active phase word |
| dp_clear | input | 1 | Holds the datapath at zero, output at midscale |
| clk_sleep | input | 1 | Freezes the datapath |
| dac_off | input | 1 | Forces the sample output to zero |
| msb_out_en | input | 1 | Selects the square waveform on the sample |
| tri_en | input | 1 | Selects the triangle waveform |
| msb_div_bypass | input | 1 | 1: square is phase MSB; 0: MSB divided by 2 |
| sample | output | 10 | Waveform sample, offset binary |
| square | output | 1 | Square output |

## Verification
The bench sweeps every sine and triangle phase point and checks the sine's exact half-wave and mirror symmetry. An off-by-one quadrant fold would break those identities at 512 or 1023. It counts the exact edge on which the waveform appears after a clear, so an extra or a missing pipeline register shows up as a wrong sample on edge N+5 or N+6. The divide-by-2 square is tracked against phase offsets that put the MSB high on the very first valid sample, which catches a toggle that counts invalid or stale samples. Sleep is checked by writing a new frequency while frozen: a design that drops that write, or keeps advancing, will diverge from the model after wake-up.

// File: rtl/dds_pkg.sv
// Package: shared default sizes and the waveform kind for the generator.
// Assumes the output selection is decoded from two static control bits.
package dds_pkg;

    localparam int ACC_W_DEF = 28;
    localparam int PH_W_DEF  = 12;
    localparam int OUT_W_DEF = 10;

    typedef enum logic [1:0] {
        WV_SINE = 2'd0,
        WV_TRI  = 2'd1,
        WV_SQ   = 2'd2
    } wave_t;

    // Map the two select bits to a waveform; the unused combination gives sine.
    function automatic wave_t pick_wave(input logic msb_en, input logic tri_en);
        if (msb_en && !tri_en)      return WV_SQ;
        else if (tri_en && !msb_en) return WV_TRI;
        else                        return WV_SINE;
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Module: word registers, phase accumulator and phase-offset adder.
// Stage 0 is the accumulator and stage 1 the offset phase. A clear zeroes both
// stages and drops the valid flags. When run is low, both stages hold.
// Word writes are taken in every state except reset.
module dds_phase_acc #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             freq_we,
    input  logic             freq_wsel,
    input  logic [ACC_W-1:0] freq_wdata,
    input  logic             phase_we,
    input  logic             phase_wsel,
    input  logic [PH_W-1:0]  phase_wdata,
    input  logic             freq_sel,
    input  logic             phase_sel,
    output logic [ACC_W-1:0] phase_o,
    output logic             valid_o
);
    localparam int SHIFT = ACC_W - PH_W;

    logic [ACC_W-1:0] freq_r [2];
    logic [PH_W-1:0]  phase_r [2];
    logic [ACC_W-1:0] acc_q;
    logic             v0_q;

    // Store programmed words; only the hardware reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_r[0]  <= '0;
            freq_r[1]  <= '0;
            phase_r[0] <= '0;
            phase_r[1] <= '0;
        end else begin
            if (freq_we)  freq_r[freq_wsel]   <= freq_wdata;
            if (phase_we) phase_r[phase_wsel] <= phase_wdata;
        end
    end

    // Advance the accumulator and form the offset phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q   <= '0;
            v0_q    <= 1'b0;
            phase_o <= '0;
            valid_o <= 1'b0;
        end else if (run) begin
            acc_q   <= acc_q + freq_r[freq_sel];
            v0_q    <= 1'b1;
            phase_o <= acc_q + {phase_r[phase_sel], {SHIFT{1'b0}}};
            valid_o <= v0_q;
        end
    end

    a_r3_acc_flush: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!valid_o && phase_o == '0));

    a_r11_acc_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> ($stable(phase_o) && $stable(valid_o)));

endmodule

// File: rtl/dds_shape.sv
// Module: converts phase to raw waveform shapes over three stages.
// Stage a folds the phase into a quarter-wave index. Stage b reads the table.
// Stage c rebuilds the offset-binary sine and forms the triangle and the gated MSB.
// The table is built at elaboration with integer Taylor arithmetic.
// Assumes OUT_W is 10 or less, which keeps that arithmetic inside 64 bits.
module dds_shape #(
    parameter int ACC_W = 28,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [ACC_W-1:0] phase_i,
    input  logic             valid_i,
    output logic [OUT_W-1:0] sine_o,
    output logic [OUT_W-1:0] tri_o,
    output logic             msb_o,
    output logic             valid_o
);
    localparam int    QW     = OUT_W - 1;
    localparam int    LUT_AW = OUT_W - 2;
    localparam int    LUT_N  = 1 << LUT_AW;
    localparam int    FX     = 30;
    localparam longint PI_FX = 64'sd3373259426;

    // Quarter-wave table: entry i = round((2^OUT_W-1)/2 * sin(pi*(2i+1)/(4*LUT_N))).
    function automatic logic [LUT_N*QW-1:0] build_quarter();
        logic [LUT_N*QW-1:0] t;
        longint x, x2, term, sum, q;
        t = '0;
        for (int i = 0; i < LUT_N; i++) begin
            x    = (longint'(2 * i + 1) * PI_FX) / longint'(4 * LUT_N);
            x2   = (x * x) >>> FX;
            term = x;
            sum  = x;
            for (int k = 1; k <= 6; k++) begin
                term = -(((term * x2) >>> FX) / longint'((2 * k) * (2 * k + 1)));
                sum  = sum + term;
            end
            q = (sum * longint'(2 * (1 << QW) - 1) + (longint'(1) <<< FX)) >>> (FX + 1);
            t[i*QW +: QW] = QW'(q);
        end
        return t;
    endfunction

    localparam logic [LUT_N*QW-1:0] QTAB = build_quarter();

    logic [1:0]        quad_a, quad_b;
    logic [LUT_AW-1:0] idx_a;
    logic [OUT_W:0]    tb_a, tb_b;
    logic [QW-1:0]     rom_b;
    logic              v_a, v_b;
    logic [OUT_W-1:0]  pidx;

    assign pidx = phase_i[ACC_W-1 -: OUT_W];

    // Stage a: split the quadrant and mirror the index in odd quadrants.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            quad_a <= '0;
            idx_a  <= '0;
            tb_a   <= '0;
            v_a    <= 1'b0;
        end else if (run) begin
            quad_a <= pidx[OUT_W-1 -: 2];
            idx_a  <= pidx[OUT_W-2] ? ~pidx[LUT_AW-1:0] : pidx[LUT_AW-1:0];
            tb_a   <= phase_i[ACC_W-1 -: OUT_W+1];
            v_a    <= valid_i;
        end
    end

    // Stage b: read the quarter-wave table.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rom_b  <= '0;
            quad_b <= '0;
            tb_b   <= '0;
            v_b    <= 1'b0;
        end else if (run) begin
            rom_b  <= QTAB[int'(idx_a)*QW +: QW];
            quad_b <= quad_a;
            tb_b   <= tb_a;
            v_b    <= v_a;
        end
    end

    // Stage c: rebuild the sine sign and form the triangle and the square bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sine_o  <= '0;
            tri_o   <= '0;
            msb_o   <= 1'b0;
            valid_o <= 1'b0;
        end else if (run) begin
            sine_o  <= quad_b[1] ? {1'b0, ~rom_b} : {1'b1, rom_b};
            tri_o   <= tb_b[OUT_W] ? ~tb_b[OUT_W-1:0] : tb_b[OUT_W-1:0];
            msb_o   <= tb_b[OUT_W] & v_b;
            valid_o <= v_b;
        end
    end

    a_r3_shape_flush: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !valid_o);

    a_r9_msb_gated: assert property (@(posedge clk) disable iff (!rst_n)
        msb_o |-> valid_o);

endmodule

// File: rtl/dds_out_sel.sv
// Module: waveform selection, divide-by-2 toggle and output register.
// Stage d picks the waveform and updates the toggle. Stage e registers the
// sample and shows midscale while the data is not valid. Power-down is applied
// after the register without a clock, so it acts at once.
module dds_out_sel #(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [OUT_W-1:0] sine_i,
    input  logic [OUT_W-1:0] tri_i,
    input  logic             msb_i,
    input  logic             valid_i,
    input  logic             msb_en,
    input  logic             tri_en,
    input  logic             div_bypass,
    input  logic             dac_off,
    output logic [OUT_W-1:0] sample_o,
    output logic             square_o
);
    import dds_pkg::*;

    localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

    wave_t            kind;
    logic             vmsb, half_nx, sq_nx;
    logic [OUT_W-1:0] sel_nx;
    logic             msb_d, half_d, sq_d, v_d;
    logic [OUT_W-1:0] sel_d;
    logic [OUT_W-1:0] sample_q;

    // Choose the waveform and the next toggle value.
    always_comb begin
        kind    = pick_wave(msb_en, tri_en);
        vmsb    = valid_i & msb_i;
        half_nx = half_d ^ (vmsb & ~msb_d);
        sq_nx   = div_bypass ? vmsb : half_nx;
        unique case (kind)
            WV_TRI:  sel_nx = tri_i;
            WV_SQ:   sel_nx = {OUT_W{sq_nx}};
            default: sel_nx = sine_i;
        endcase
    end

    // Stage d: hold the selection, the edge detector and the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            msb_d  <= 1'b0;
            half_d <= 1'b0;
            sq_d   <= 1'b0;
            sel_d  <= '0;
            v_d    <= 1'b0;
        end else if (run) begin
            msb_d  <= vmsb;
            half_d <= half_nx;
            sq_d   <= sq_nx;
            sel_d  <= sel_nx;
            v_d    <= valid_i;
        end
    end

    // Stage e: output register, midscale until data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sample_q <= MID;
            square_o <= 1'b0;
        end else if (run) begin
            sample_q <= v_d ? sel_d : MID;
            square_o <= v_d & sq_d;
        end
    end

    assign sample_o = dac_off ? '0 : sample_q;

    a_r3_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dac_off || (sample_o == MID && !square_o)));

    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> ($stable(sample_q) && $stable(square_o)));

    a_r9_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !(vmsb && !msb_d)) |=> $stable(half_d));

endmodule

// File: rtl/dds_wavegen.sv
// Module: top of the numerically controlled waveform generator.
// Connects the phase stage, the shape stage and the output stage. The datapath
// is seven registers deep from the accumulator to the sample. The control bits
// are expected to stay static, or to change only while the clear is held.
module dds_wavegen #(
    parameter int ACC_W = dds_pkg::ACC_W_DEF,
    parameter int PH_W  = dds_pkg::PH_W_DEF,
    parameter int OUT_W = dds_pkg::OUT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_we,
    input  logic             freq_wsel,
    input  logic [ACC_W-1:0] freq_wdata,
    input  logic             phase_we,
    input  logic             phase_wsel,
    input  logic [PH_W-1:0]  phase_wdata,
    input  logic             freq_sel,
    input  logic             phase_sel,
    input  logic             dp_clear,
    input  logic             clk_sleep,
    input  logic             dac_off,
    input  logic             msb_out_en,
    input  logic             tri_en,
    input  logic             msb_div_bypass,
    output logic [OUT_W-1:0] sample,
    output logic             square
);
    logic             run;
    logic [ACC_W-1:0] phase_w;
    logic             phase_v;
    logic [OUT_W-1:0] sine_w, tri_w;
    logic             msb_w, shape_v;

    assign run = ~clk_sleep;

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(dp_clear), .run(run),
        .freq_we(freq_we), .freq_wsel(freq_wsel), .freq_wdata(freq_wdata),
        .phase_we(phase_we), .phase_wsel(phase_wsel), .phase_wdata(phase_wdata),
        .freq_sel(freq_sel), .phase_sel(phase_sel),
        .phase_o(phase_w), .valid_o(phase_v)
    );

    dds_shape #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shape (
        .clk(clk), .rst_n(rst_n), .clear(dp_clear), .run(run),
        .phase_i(phase_w), .valid_i(phase_v),
        .sine_o(sine_w), .tri_o(tri_w), .msb_o(msb_w), .valid_o(shape_v)
    );

    dds_out_sel #(.OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(dp_clear), .run(run),
        .sine_i(sine_w), .tri_i(tri_w), .msb_i(msb_w), .valid_i(shape_v),
        .msb_en(msb_out_en), .tri_en(tri_en), .div_bypass(msb_div_bypass),
        .dac_off(dac_off), .sample_o(sample), .square_o(square)
    );

endmodule

// File: tb/dds_wavegen_test.sv
`timescale 1ns/1ps
module dds_wavegen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_we = 0, freq_wsel = 0, phase_we = 0, phase_wsel = 0;
    logic [27:0] freq_wdata = '0;
    logic [11:0] phase_wdata = '0;
    logic        freq_sel = 0, phase_sel = 0, dp_clear = 0, clk_sleep = 0;
    logic        dac_off = 0, msb_out_en = 0, tri_en = 0, msb_div_bypass = 1;
    logic [9:0]  sample;
    logic        square;

    int checks = 0, failures = 0;
    bit done = 0;

    // model state
    logic [27:0] fr [2];
    logic [11:0] pr [2];
    logic [27:0] macc;
    bit          mv;
    logic [27:0] m_ph [1:6];
    bit          m_v [1:6];
    bit          m_h [1:6];
    int          sv [1024];
    bit          seen [1024];

    always #2 clk = ~clk;

    dds_wavegen uut (
        .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_wsel(freq_wsel),
        .freq_wdata(freq_wdata), .phase_we(phase_we), .phase_wsel(phase_wsel),
        .phase_wdata(phase_wdata), .freq_sel(freq_sel), .phase_sel(phase_sel),
        .dp_clear(dp_clear), .clk_sleep(clk_sleep), .dac_off(dac_off),
        .msb_out_en(msb_out_en), .tri_en(tri_en), .msb_div_bypass(msb_div_bypass),
        .sample(sample), .square(square)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit vm(input int j);
        return m_v[j] && m_ph[j][27];
    endfunction

    task automatic model_clear();
        macc = '0; mv = 0;
        for (int j = 1; j <= 6; j++) begin m_ph[j] = '0; m_v[j] = 0; m_h[j] = 0; end
    endtask

    // One clock: model follows the edge, then return at the falling edge.
    task automatic tick();
        bit nh;
        @(posedge clk);
        if (!rst_n) begin
            model_clear();
            fr[0] = '0; fr[1] = '0; pr[0] = '0; pr[1] = '0;
        end else begin
            if (dp_clear) model_clear();
            else if (!clk_sleep) begin
                nh = m_h[5] ^ (vm(4) && !vm(5));
                m_ph[6] = m_ph[5]; m_v[6] = m_v[5]; m_h[6] = m_h[5];
                m_ph[5] = m_ph[4]; m_v[5] = m_v[4]; m_h[5] = nh;
                for (int j = 4; j >= 2; j--) begin m_ph[j] = m_ph[j-1]; m_v[j] = m_v[j-1]; end
                m_ph[1] = macc + {pr[phase_sel], 16'b0}; m_v[1] = mv;
                macc = macc + fr[freq_sel]; mv = 1;
            end
            if (freq_we)  fr[freq_wsel]   = freq_wdata;
            if (phase_we) pr[phase_wsel] = phase_wdata;
        end
        @(negedge clk);
    endtask

    // Compare the ports with the model's output entry.
    task automatic check_now(input string req);
        int  p, t, es;
        bit  esq;
        real e, d;
        esq = m_v[6] && (msb_div_bypass ? m_ph[6][27] : m_h[6]);
        chk(square == esq, req, "square", square, esq);
        if (dac_off) begin
            chk(sample == 0, req, "sample(powered down)", sample, 0);
        end else if (!m_v[6]) begin
            chk(sample == 512, req, "sample(midscale)", sample, 512);
        end else if (msb_out_en && !tri_en) begin
            es = esq ? 1023 : 0;
            chk(sample == es, req, "sample(square)", sample, es);
        end else if (tri_en && !msb_out_en) begin
            t  = int'(m_ph[6][27:17]);
            es = (t >= 1024) ? (2047 - t) : t;
            chk(sample == es, req, "sample(triangle)", sample, es);
        end else begin
            p = int'(m_ph[6][27:18]);
            e = 511.5 + 511.5 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
            d = real'(sample) - e;
            if (d < 0.0) d = -d;
            chk(d <= 1.0, req, "sample(sine)", sample, $rtoi(e + 0.5));
            sv[p] = int'(sample); seen[p] = 1;
        end
    endtask

    task automatic sweep(input int n, input string req);
        for (int i = 0; i < n; i++) begin tick(); check_now(req); end
    endtask

    task automatic wr_freq(input bit s, input logic [27:0] d);
        freq_we = 1; freq_wsel = s; freq_wdata = d; tick(); freq_we = 0;
    endtask

    task automatic wr_phase(input bit s, input logic [11:0] d);
        phase_we = 1; phase_wsel = s; phase_wdata = d; tick(); phase_we = 0;
    endtask

    task automatic restart(input string req);
        dp_clear = 1; tick(); check_now(req); tick(); check_now(req); dp_clear = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [9:0] frozen;
        bit         fsq;
        model_clear();
        for (int k = 0; k < 1024; k++) begin seen[k] = 0; sv[k] = 0; end
        @(negedge clk);
        tick(); tick();
        chk(sample == 512, "R3", "reset sample", sample, 512);
        chk(square == 0, "R3", "reset square", square, 0);
        rst_n = 1;

        // R4 latency and R5 sine, one index step per clock
        wr_freq(0, 28'h0040000);
        wr_phase(0, 12'h000);
        restart("R3");
        for (int i = 1; i <= 7; i++) begin
            tick();
            if (i <= 6) chk(sample == 512, "R4", "before waveform", sample, 512);
            else        chk(sample != 512, "R4", "first waveform edge", sample, 517);
            check_now("R4");
        end
        sweep(1030, "R5");
        for (int p = 0; p < 512; p++) begin
            chk(seen[p] && seen[p+512] && (sv[p] + sv[p+512] == 1023), "R6",
                "half-wave sum", sv[p] + sv[p+512], 1023);
            chk(sv[p] == sv[511-p], "R6", "mirror", sv[p], sv[511-p]);
        end

        // R7 triangle from the second frequency word (R2)
        wr_freq(1, 28'h0020000);
        freq_sel = 1; tri_en = 1;
        restart("R2");
        sweep(2060, "R7");

        // R1 phase offset from the second phase word with an odd frequency
        tri_en = 0;
        wr_phase(1, 12'hA37);
        wr_freq(0, 28'h1234567);
        freq_sel = 0; phase_sel = 1;
        restart("R1");
        sweep(1500, "R1");

        // R2 live switching of the active word
        freq_sel = 1; sweep(40, "R2");
        phase_sel = 0; sweep(40, "R2");

        // R8 square direct and R9 divided, offset puts MSB high at start
        msb_out_en = 1; msb_div_bypass = 1; freq_sel = 0; phase_sel = 1;
        wr_freq(0, 28'h0100000);
        restart("R8");
        sweep(600, "R8");
        msb_div_bypass = 0;
        restart("R9");
        sweep(1100, "R9");

        // R12 power-down acts at once, square continues
        dac_off = 1; #1;
        chk(sample == 0, "R12", "immediate power-down", sample, 0);
        sweep(300, "R12");
        dac_off = 0; #1;
        check_now("R12");

        // R10 reserved selection gives the sine
        tri_en = 1; msb_div_bypass = 1;
        restart("R10");
        sweep(300, "R10");

        // R11 sleep: hold, accept a write, resume
        tri_en = 0; msb_out_en = 0;
        restart("R11");
        sweep(100, "R11");
        clk_sleep = 1;
        frozen = sample; fsq = square;
        for (int i = 0; i < 20; i++) begin
            if (i == 5) wr_freq(0, 28'h0350000); else tick();
            chk(sample == frozen, "R11", "held sample", sample, frozen);
            chk(square == fsq, "R11", "held square", square, fsq);
        end
        clk_sleep = 0;
        sweep(400, "R11");

        // R3 clear keeps words: restart and continue with the stored words
        restart("R3");
        sweep(200, "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule